// File: doc/BRIEF.md
# Approximate Integer Square Root with Leading-One Windowing

This block returns an approximate integer square root of a 16-bit unsigned radicand. It does not run a full-width root array. A leading-one search picks a 6-bit slice of the radicand. The slice starts at the highest set bit, and its lower edge is moved down to an even bit position. Every bit below the slice is dropped. A 3-bit exact root of the slice is then produced, either by a digit-recurrence core or by a 64-entry table. That root is shifted left by half the number of dropped bits. The result is never larger than the exact root, and the error is bounded by the amount of pruning.

The block is a two-stage pipeline. It accepts one radicand per cycle, and each result appears two cycles later with a valid flag. A parameter selects the core variant. Both variants return the same result for every input.

Top module: `apx_sqrt_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_root` are 0 after that edge. This includes a reset that arrives while a radicand is still in the pipeline.
- R2: A radicand presented with `in_valid` high at clock edge N gives `out_valid` high after edge N+2. Radicands may be presented on every cycle, and gaps in `in_valid` give gaps in `out_valid`.
- R3: The result never exceeds the exact root: `out_root*out_root <= radicand`.
- R4: Let L be the number of significant bits of the radicand (leading-one position plus 1). Let s = ceil(max(0, L-6)/2). Then the exact floor root minus `out_root` is less than 2^s. For the all-ones radicand this gives at most 31.
- R5: The result equals floor(sqrt(radicand >> 2s)) << s, with s as in R4. The window therefore always sits on an even bit boundary, and the 6-bit slice fed to the core has a 1 in one of its two top bits.
- R6: A radicand below 64 has at most 6 significant bits. It is used whole, zero-extended above, and gives the exact floor root.
- R7: A zero radicand gives a zero root.
- R8: When `out_valid` is low, `out_root` is 0.
- R9: The table variant (`USE_LUT=1`, entry i holds floor(sqrt(i)) for i = 0..63) and the computed variant (`USE_LUT=0`) give identical results for every radicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Radicand qualifier |
| in_rad | input | 16 | Unsigned radicand |
| out_valid | output | 1 | Result qualifier, two cycles after input |
| out_root | output | 8 | Approximate floor square root |

## Verification
In the same cycle, one result leaves the output register while the next radicand enters the window stage. A second result can also be in the core at that moment.

The bench creates this overlap by feeding a table of vectors, and then all 65536 radicands, on consecutive cycles. Each output is checked against the radicand presented two cycles earlier, and against the other core variant in that same cycle.

A reset applied while a radicand is still in the pipeline must discard it. This is checked at the ports as well.

// File: rtl/apx_sqrt_pkg.sv
package apx_sqrt_pkg;
  // floor square root used to build the table at elaboration
  function automatic int unsigned isqrt_const(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction
endpackage

// File: rtl/apx_sqrt_window.sv
module apx_sqrt_window #(
  parameter int IN_W  = 16,
  parameter int WIN_W = 6,
  parameter int SH_W  = 4
) (
  input  logic [IN_W-1:0]  rad,
  output logic [WIN_W-1:0] win,
  output logic [SH_W-1:0]  half_shift
);
  int sig_bits;
  int drop_bits;
  int hs;

  always_comb begin
    sig_bits = 0;
    for (int b = 0; b < IN_W; b++) begin
      if (rad[b]) sig_bits = b + 1;
    end
    drop_bits  = (sig_bits > WIN_W) ? sig_bits - WIN_W : 0;
    hs         = (drop_bits + 1) / 2;   // round dropped count up to even
    win        = WIN_W'(rad >> (2 * hs));
    half_shift = SH_W'(hs);
  end
endmodule

// File: rtl/apx_sqrt_core.sv
module apx_sqrt_core #(
  parameter int WIN_W   = 6,
  parameter int CORE_W  = 3,
  parameter bit USE_LUT = 1'b0
) (
  input  logic [WIN_W-1:0]  win,
  output logic [CORE_W-1:0] root
);
  import apx_sqrt_pkg::*;

  generate
    if (USE_LUT) begin : g_tab
      localparam int DEPTH = 1 << WIN_W;
      logic [CORE_W-1:0] tab [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign tab[i] = CORE_W'(isqrt_const(i));
      end
      assign root = tab[win];
    end else begin : g_calc
      localparam int REM_W = CORE_W + 3;
      logic [CORE_W-1:0] acc;
      logic [REM_W-1:0]  rem;
      logic [REM_W-1:0]  trial;
      always_comb begin
        acc   = '0;
        rem   = '0;
        trial = '0;
        for (int i = CORE_W - 1; i >= 0; i--) begin
          rem   = {rem[REM_W-3:0], win[2*i+1 -: 2]};
          trial = {1'b0, acc, 2'b01};
          if (rem >= trial) begin
            rem = rem - trial;
            acc = {acc[CORE_W-2:0], 1'b1};
          end else begin
            acc = {acc[CORE_W-2:0], 1'b0};
          end
        end
      end
      assign root = acc;
    end
  endgenerate
endmodule

// File: rtl/apx_sqrt_top.sv
module apx_sqrt_top #(
  parameter int IN_W    = 16,
  parameter int WIN_W   = 6,
  parameter bit USE_LUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_rad,
  output logic              out_valid,
  output logic [IN_W/2-1:0] out_root
);
  localparam int ROOT_W = IN_W / 2;
  localparam int CORE_W = WIN_W / 2;
  localparam int SH_W   = $clog2(ROOT_W + 1);

  logic [WIN_W-1:0]  win_c;
  logic [SH_W-1:0]   hs_c;
  logic              s1_valid;
  logic [WIN_W-1:0]  s1_win;
  logic [SH_W-1:0]   s1_hs;
  logic [CORE_W-1:0] core_root;

  apx_sqrt_window #(.IN_W(IN_W), .WIN_W(WIN_W), .SH_W(SH_W)) u_win (
    .rad(in_rad), .win(win_c), .half_shift(hs_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_win   <= '0;
      s1_hs    <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_win   <= win_c;
      s1_hs    <= hs_c;
    end
  end

  apx_sqrt_core #(.WIN_W(WIN_W), .CORE_W(CORE_W), .USE_LUT(USE_LUT)) u_core (
    .win(s1_win), .root(core_root)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_root  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_root  <= s1_valid ? (ROOT_W'(core_root) << s1_hs) : '0;
    end
  end
endmodule

// File: rtl/apx_sqrt_chk.sv
module apx_sqrt_chk #(
  parameter int IN_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [IN_W-1:0]   in_rad,
  input logic              out_valid,
  input logic [IN_W/2-1:0] out_root
);
  logic [1:0]    vsh;
  logic [IN_W:0] sq;
  logic [IN_W:0] sq_next;

  always_ff @(posedge clk) begin
    if (rst) vsh <= '0;
    else     vsh <= {vsh[0], in_valid};
  end

  assign sq      = (IN_W+1)'(out_root) * (IN_W+1)'(out_root);
  assign sq_next = ((IN_W+1)'(out_root) + 1'b1) * ((IN_W+1)'(out_root) + 1'b1);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsh[1]);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> sq <= (IN_W+1)'($past(in_rad, 2)));

  assert_small_exact_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rad < 64) |=> ##1 (sq <= (IN_W+1)'($past(in_rad, 2)) && sq_next > (IN_W+1)'($past(in_rad, 2))));

  assert_zero_root_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rad == '0) |=> ##1 (out_root == '0));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_root == '0);
endmodule

bind apx_sqrt_top apx_sqrt_chk #(.IN_W(IN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_rad(in_rad),
  .out_valid(out_valid), .out_root(out_root)
);

// File: tb/apx_sqrt_top_test.sv
module apx_sqrt_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_rad = '0;
  logic        out_valid, out_valid_t;
  logic [7:0]  out_root, out_root_t;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  apx_sqrt_top #(.IN_W(16), .WIN_W(6), .USE_LUT(1'b0)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_rad(in_rad),
    .out_valid(out_valid), .out_root(out_root));

  apx_sqrt_top #(.IN_W(16), .WIN_W(6), .USE_LUT(1'b1)) uut_tab (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_rad(in_rad),
    .out_valid(out_valid_t), .out_root(out_root_t));

  // radicand, expected root (from R5)
  localparam logic [23:0] VEC [12] = '{
    {16'd0, 8'd0}, {16'd1, 8'd1}, {16'd63, 8'd7}, {16'd64, 8'd8},
    {16'd100, 8'd10}, {16'd255, 8'd14}, {16'd256, 8'd16}, {16'd1000, 8'd28},
    {16'd12345, 8'd96}, {16'h4000, 8'd128}, {16'h8000, 8'd160}, {16'hFFFF, 8'd224}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exact_root(input int x);
    int r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  function automatic int half_drop(input int x);
    int sig = 0;
    int d;
    for (int b = 0; b < 16; b++) if (x[b]) sig = b + 1;
    d = (sig > 6) ? sig - 6 : 0;
    return (d + 1) / 2;
  endfunction

  function automatic int model_root(input int x);
    int s = half_drop(x);
    return exact_root(x >> (2 * s)) << s;
  endfunction

  task automatic judge(input int x);
    int r = int'(out_root);
    int e = exact_root(x);
    int s = half_drop(x);
    chk("R2 out_valid", int'(out_valid), 1);
    chk("R5 windowed root", r, model_root(x));
    chk("R3 no overshoot", int'(r * r <= x), 1);
    chk("R4 error bound", int'(e >= r && (e - r) < (1 << s)), 1);
    chk("R9 table matches computed", int'(out_root_t), r);
    if (x < 64) chk("R6 small exact", r, e);
    if (x == 0) chk("R7 zero", r, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset root", int'(out_root), 0);
    rst = 1'b0;

    // vector table, back-to-back
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R2 table valid", int'(out_valid), 1);
        chk("R5 table root", int'(out_root), int'(VEC[i-2][7:0]));
        chk("R9 table variant", int'(out_root_t), int'(VEC[i-2][7:0]));
      end
      in_valid = (i < 12);
      in_rad   = (i < 12) ? VEC[i][23:8] : 16'd0;
    end

    // full sweep, every cycle
    for (int i = 0; i < 65538; i++) begin
      @(negedge clk);
      if (i >= 2) judge(i - 2);
      in_valid = (i < 65536);
      in_rad   = 16'(i);
    end

    // gap pattern
    @(negedge clk);
    in_valid = 1'b1; in_rad = 16'd1000;
    @(negedge clk);
    in_valid = 1'b0; in_rad = 16'hFFFF;
    chk("R8 idle valid", int'(out_valid), 0);
    chk("R8 idle root", int'(out_root), 0);
    @(negedge clk);
    chk("R2 gap valid", int'(out_valid), 1);
    chk("R2 gap root", int'(out_root), 28);
    @(negedge clk);
    chk("R2 gap hole", int'(out_valid), 0);
    chk("R8 root zero when idle", int'(out_root), 0);

    // reset with a value in flight
    in_valid = 1'b1; in_rad = 16'hFFFF;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 flush valid", int'(out_valid), 0);
    chk("R1 flush root", int'(out_root), 0);
    @(negedge clk);
    chk("R1 flush valid late", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 nothing after reset", int'(out_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule